// File: doc/BRIEF.md
# Voltage and Frequency Step Sequencer

This block moves a core between a small set of operating points, each of which pairs a clock frequency code with a supply voltage code. A frequency code counts 33 MHz units and a voltage code counts 25 mV units. Point `i` uses frequency code `F_BASE + F_PER_PT*i` and voltage code `V_BASE + V_PER_PT*i`, so a higher index means both a faster clock and a higher supply. A move can be requested in three ways: by periodic idle-time samples from an activity monitor, by a thermal trigger, or by a software request that names a target point directly.

The order of a transition depends on its direction. Going down, the block halts execution and asks the PLL to lock at the lower frequency code. It keeps execution halted until the PLL acknowledges lock, and only then walks the voltage code down. Going up, it walks the voltage code up first, and then halts and relocks the PLL at the higher frequency. The voltage always moves one code per ready pulse from the external regulator. A request that arrives while a transition is running is held in one pending slot and is serviced once the running transition has finished.

Top module: `vfStepSeq`

## Requirements
- R1: After reset the current point is `RST_PT` (default 3). The frequency code and voltage code are those of that point (21 and 34 with the defaults). `haltExec`, `pllLockReq` and `busy` are low.
- R2: When a transition to point `p` completes, `curPoint` equals `p`, `freqCode` equals `F_BASE + F_PER_PT*p` and `voltCode` equals `V_BASE + V_PER_PT*p` (defaults 12, 3, 28, 2).
- R3: An idle sample (`idleValid` high) with `idleSample >= IDLE_HI` (default 200) requests one point lower.
- R4: `ACT_RUN` consecutive idle samples (default 3) with `idleSample <= ACT_LO` (default 40) request one point higher. Any sample above `ACT_LO` restarts the count.
- R5: The point index saturates at 0 and at `NUM_PTS-1` (default 5). A software target above `NUM_PTS-1` is clamped to `NUM_PTS-1`.
- R6: In a downward transition, `haltExec` and `pllLockReq` rise while `freqCode` already shows the new value and `voltCode` still shows the old one. The voltage code does not move while execution is halted.
- R7: In an upward transition, `voltCode` reaches the new level while `freqCode` keeps the old value. Only after that does `freqCode` change, with `haltExec` and `pllLockReq` high.
- R8: `haltExec` stays high until `pllLockAck` is sampled high, and falls in the cycle after that.
- R9: `voltCode` changes only in a cycle after `regReady` was high, and by exactly one code.
- R10: `thermTrig` requests one point lower. `swReq` requests the point `swTarget`. When both arrive in the same cycle, the thermal request wins.
- R11: A request made while a transition is running is held and then serviced. A step request made during a transition counts from that transition's destination point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleValid | input | 1 | Idle sample strobe |
| idleSample | input | IDLE_W | Sampled idle time |
| thermTrig | input | 1 | Thermal trigger pulse |
| swReq | input | 1 | Software request pulse |
| swTarget | input | IDX_W | Target point for a software request |
| pllLockAck | input | 1 | PLL reports lock at the requested code |
| regReady | input | 1 | Regulator accepts one voltage code step |
| haltExec | output | 1 | Execution halt |
| pllLockReq | output | 1 | Request for the PLL to lock at `freqCode` |
| freqCode | output | FCODE_W | Frequency code (33 MHz units) |
| voltCode | output | VCODE_W | Voltage code (25 mV units) |
| curPoint | output | IDX_W | Current operating point index |
| busy | output | 1 | A transition is running or a request is pending |

## Verification
The main function is exercised with a table of mixed requests: high-idle samples, runs of activity, thermal pulses and software targets both near and far. Each request starts from a known point, so both step directions and multi-point jumps are covered. For every step the bench records the voltage code at the moment the frequency code changes. That value tells a correct halt-then-relock-then-slew order apart from a reversed one. Directed cases withhold the lock acknowledge or the regulator pulses to hold a transition in its halt or ramp phase. Further cases break an activity run, fire thermal and software requests in the same cycle, and issue a request in the middle of a ramp.

// File: rtl/vfseq_pkg.sv
package vfseq_pkg;

  typedef struct packed {
    logic loadTgt;
    logic setFreq;
    logic stepUp;
    logic stepDn;
    logic commit;
  } vfStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PICK,
    S_DN_HALT,
    S_DN_VOLT,
    S_UP_VOLT,
    S_UP_HALT
  } vfState_t;

endpackage

// File: rtl/vfseqPath.sv
module vfseqPath
  import vfseq_pkg::*;
#(
  parameter int NUM_PTS  = 6,
  parameter int IDX_W    = 3,
  parameter int FCODE_W  = 8,
  parameter int VCODE_W  = 8,
  parameter int IDLE_W   = 8,
  parameter int F_BASE   = 12,
  parameter int F_PER_PT = 3,
  parameter int V_BASE   = 28,
  parameter int V_PER_PT = 2,
  parameter int RST_PT   = 3,
  parameter int IDLE_HI  = 200,
  parameter int ACT_LO   = 40,
  parameter int ACT_RUN  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               idleValid,
  input  logic [IDLE_W-1:0]  idleSample,
  input  logic               thermTrig,
  input  logic               swReq,
  input  logic [IDX_W-1:0]   swTarget,
  input  vfStrobe_t          strobe,
  output logic [IDX_W-1:0]   curPoint,
  output logic [FCODE_W-1:0] freqCode,
  output logic [VCODE_W-1:0] voltCode,
  output logic               pendValid,
  output logic               tgtAbove,
  output logic               tgtBelow,
  output logic               voltAtTgt
);

  localparam int ACT_W = (ACT_RUN > 1) ? $clog2(ACT_RUN + 1) : 1;
  localparam logic [IDX_W-1:0]  MAX_IDX  = IDX_W'(NUM_PTS - 1);
  localparam logic [IDX_W-1:0]  RST_IDX  = IDX_W'(RST_PT);
  localparam logic [IDLE_W-1:0] HI_LIM   = IDLE_W'(IDLE_HI);
  localparam logic [IDLE_W-1:0] LO_LIM   = IDLE_W'(ACT_LO);
  localparam logic [ACT_W-1:0]  RUN_LAST = ACT_W'(ACT_RUN - 1);

  function automatic logic [FCODE_W-1:0] freqOf(input logic [IDX_W-1:0] p);
    return FCODE_W'(F_BASE + F_PER_PT * int'(p));
  endfunction

  function automatic logic [VCODE_W-1:0] voltOf(input logic [IDX_W-1:0] p);
    return VCODE_W'(V_BASE + V_PER_PT * int'(p));
  endfunction

  logic [IDX_W-1:0] tgtPoint;
  logic [IDX_W-1:0] pendTgt;
  logic [ACT_W-1:0] actCnt;

  logic [IDX_W-1:0] basePt, baseDn, baseUp, swClamp;
  logic             idleHigh, actLow, actHit;
  logic             reqValid;
  logic [IDX_W-1:0] reqTgt;

  // Step requests count from the newest committed destination
  always_comb begin
    basePt   = pendValid ? pendTgt : tgtPoint;
    baseDn   = (basePt == '0) ? basePt : basePt - 1'b1;
    baseUp   = (basePt >= MAX_IDX) ? MAX_IDX : basePt + 1'b1;
    swClamp  = (swTarget > MAX_IDX) ? MAX_IDX : swTarget;
    idleHigh = idleValid && (idleSample >= HI_LIM);
    actLow   = idleValid && (idleSample <= LO_LIM);
    actHit   = actLow && (actCnt == RUN_LAST);
  end

  // Priority: thermal, software, idle, activity
  always_comb begin
    reqValid = 1'b1;
    reqTgt   = basePt;
    if (thermTrig)     reqTgt = baseDn;
    else if (swReq)    reqTgt = swClamp;
    else if (idleHigh) reqTgt = baseDn;
    else if (actHit)   reqTgt = baseUp;
    else               reqValid = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCnt <= '0;
    end else if (idleValid) begin
      if (!actLow)     actCnt <= '0;
      else if (actHit) actCnt <= '0;
      else             actCnt <= actCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendTgt   <= RST_IDX;
    end else if (reqValid) begin
      pendValid <= 1'b1;
      pendTgt   <= reqTgt;
    end else if (strobe.loadTgt) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtPoint <= RST_IDX;
      curPoint <= RST_IDX;
      freqCode <= freqOf(RST_IDX);
      voltCode <= voltOf(RST_IDX);
    end else begin
      if (strobe.loadTgt) tgtPoint <= pendTgt;
      if (strobe.commit)  curPoint <= tgtPoint;
      if (strobe.setFreq) freqCode <= freqOf(tgtPoint);
      if (strobe.stepUp)  voltCode <= voltCode + 1'b1;
      else if (strobe.stepDn) voltCode <= voltCode - 1'b1;
    end
  end

  always_comb begin
    tgtAbove  = tgtPoint > curPoint;
    tgtBelow  = tgtPoint < curPoint;
    voltAtTgt = voltCode == voltOf(tgtPoint);
  end

endmodule

// File: rtl/vfseqCtrl.sv
module vfseqCtrl
  import vfseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pendValid,
  input  logic      tgtAbove,
  input  logic      tgtBelow,
  input  logic      voltAtTgt,
  input  logic      pllLockAck,
  input  logic      regReady,
  output vfStrobe_t strobe,
  output logic      haltExec,
  output logic      pllLockReq,
  output logic      running
);

  vfState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      S_IDLE: begin
        if (pendValid) begin
          strobe.loadTgt = 1'b1;
          stateNxt       = S_PICK;
        end
      end
      S_PICK: begin
        if (tgtBelow) begin
          strobe.setFreq = 1'b1;
          stateNxt       = S_DN_HALT;
        end else if (tgtAbove) begin
          stateNxt = S_UP_VOLT;
        end else begin
          stateNxt = S_IDLE;
        end
      end
      S_DN_HALT: begin
        if (pllLockAck) stateNxt = S_DN_VOLT;
      end
      S_DN_VOLT: begin
        if (voltAtTgt) begin
          strobe.commit = 1'b1;
          stateNxt      = S_IDLE;
        end else if (regReady) begin
          strobe.stepDn = 1'b1;
        end
      end
      S_UP_VOLT: begin
        if (voltAtTgt) begin
          strobe.setFreq = 1'b1;
          stateNxt       = S_UP_HALT;
        end else if (regReady) begin
          strobe.stepUp = 1'b1;
        end
      end
      S_UP_HALT: begin
        if (pllLockAck) begin
          strobe.commit = 1'b1;
          stateNxt      = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    haltExec   = (state == S_DN_HALT) || (state == S_UP_HALT);
    pllLockReq = haltExec;
    running    = state != S_IDLE;
  end

endmodule

// File: rtl/vfStepSeq.sv
module vfStepSeq
  import vfseq_pkg::*;
#(
  parameter int NUM_PTS  = 6,
  parameter int FCODE_W  = 8,
  parameter int VCODE_W  = 8,
  parameter int IDLE_W   = 8,
  parameter int F_BASE   = 12,
  parameter int F_PER_PT = 3,
  parameter int V_BASE   = 28,
  parameter int V_PER_PT = 2,
  parameter int RST_PT   = 3,
  parameter int IDLE_HI  = 200,
  parameter int ACT_LO   = 40,
  parameter int ACT_RUN  = 3,
  localparam int IDX_W   = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               idleValid,
  input  logic [IDLE_W-1:0]  idleSample,
  input  logic               thermTrig,
  input  logic               swReq,
  input  logic [IDX_W-1:0]   swTarget,
  input  logic               pllLockAck,
  input  logic               regReady,
  output logic               haltExec,
  output logic               pllLockReq,
  output logic [FCODE_W-1:0] freqCode,
  output logic [VCODE_W-1:0] voltCode,
  output logic [IDX_W-1:0]   curPoint,
  output logic               busy
);

  vfStrobe_t strobe;
  logic pendValid, tgtAbove, tgtBelow, voltAtTgt, running;

  vfseqPath #(
    .NUM_PTS(NUM_PTS), .IDX_W(IDX_W), .FCODE_W(FCODE_W), .VCODE_W(VCODE_W),
    .IDLE_W(IDLE_W), .F_BASE(F_BASE), .F_PER_PT(F_PER_PT), .V_BASE(V_BASE),
    .V_PER_PT(V_PER_PT), .RST_PT(RST_PT), .IDLE_HI(IDLE_HI), .ACT_LO(ACT_LO),
    .ACT_RUN(ACT_RUN)
  ) uPath (
    .clk(clk), .rstN(rstN), .idleValid(idleValid), .idleSample(idleSample),
    .thermTrig(thermTrig), .swReq(swReq), .swTarget(swTarget), .strobe(strobe),
    .curPoint(curPoint), .freqCode(freqCode), .voltCode(voltCode),
    .pendValid(pendValid), .tgtAbove(tgtAbove), .tgtBelow(tgtBelow),
    .voltAtTgt(voltAtTgt)
  );

  vfseqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .pendValid(pendValid), .tgtAbove(tgtAbove),
    .tgtBelow(tgtBelow), .voltAtTgt(voltAtTgt), .pllLockAck(pllLockAck),
    .regReady(regReady), .strobe(strobe), .haltExec(haltExec),
    .pllLockReq(pllLockReq), .running(running)
  );

  assign busy = running || pendValid;

endmodule

// File: rtl/vfseqChecker.sv
module vfseqChecker #(
  parameter int NUM_PTS = 6,
  parameter int IDX_W   = 3,
  parameter int FCODE_W = 8,
  parameter int VCODE_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               haltExec,
  input logic               pllLockAck,
  input logic               regReady,
  input logic [FCODE_W-1:0] freqCode,
  input logic [VCODE_W-1:0] voltCode,
  input logic [IDX_W-1:0]   curPoint
);

  AST_POINT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(curPoint) < NUM_PTS); // R5

  AST_VSTEP_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (voltCode != $past(voltCode)) |-> $past(regReady)); // R9

  AST_VSTEP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (voltCode != $past(voltCode)) |->
      ((voltCode == $past(voltCode) + 1'b1) || (voltCode == $past(voltCode) - 1'b1))); // R9

  AST_NO_VSTEP_IN_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (voltCode != $past(voltCode)) |-> !$past(haltExec)); // R6

  AST_FREQ_UNDER_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (freqCode != $past(freqCode)) |-> haltExec); // R7

  AST_HALT_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(haltExec) && !$past(pllLockAck)) |-> haltExec); // R8

  AST_HALT_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(haltExec) && $past(pllLockAck)) |-> !haltExec); // R8

endmodule

bind vfStepSeq vfseqChecker #(
  .NUM_PTS(NUM_PTS), .IDX_W(IDX_W), .FCODE_W(FCODE_W), .VCODE_W(VCODE_W)
) uChk (
  .clk(clk), .rstN(rstN), .haltExec(haltExec), .pllLockAck(pllLockAck),
  .regReady(regReady), .freqCode(freqCode), .voltCode(voltCode),
  .curPoint(curPoint)
);

// File: tb/sim_vfStepSeq.sv
`timescale 1ns/1ps
module sim_vfStepSeq;

  localparam int NPTS = 6;
  localparam int IW   = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idleValid = 1'b0;
  logic [7:0] idleSample = '0;
  logic       thermTrig = 1'b0;
  logic       swReq = 1'b0;
  logic [IW-1:0] swTarget = '0;
  logic       pllLockAck = 1'b0;
  logic       regReady = 1'b0;
  logic       haltExec, pllLockReq, busy;
  logic [7:0] freqCode, voltCode;
  logic [IW-1:0] curPoint;

  int checks = 0;
  int fails  = 0;
  bit ackEn  = 1'b1;
  bit regEn  = 1'b1;
  bit done   = 1'b0;
  int freqChgV = -1;
  int haltStepErr = 0;

  always #4 clk = ~clk;

  vfStepSeq u0 (
    .clk(clk), .rstN(rstN), .idleValid(idleValid), .idleSample(idleSample),
    .thermTrig(thermTrig), .swReq(swReq), .swTarget(swTarget),
    .pllLockAck(pllLockAck), .regReady(regReady), .haltExec(haltExec),
    .pllLockReq(pllLockReq), .freqCode(freqCode), .voltCode(voltCode),
    .curPoint(curPoint), .busy(busy)
  );

  function automatic int fOf(int p); return 12 + 3 * p; endfunction
  function automatic int vOf(int p); return 28 + 2 * p; endfunction

  // kind: 0 high idle, 1 activity run, 2 thermal, 3 software; {kind, arg, expected point}
  localparam logic [7:0] VEC [10] = '{
    {2'd0, 3'd0, 3'd2}, {2'd2, 3'd0, 3'd1}, {2'd2, 3'd0, 3'd0}, {2'd2, 3'd0, 3'd0},
    {2'd3, 3'd4, 3'd4}, {2'd1, 3'd0, 3'd5}, {2'd1, 3'd0, 3'd5}, {2'd3, 3'd7, 3'd5},
    {2'd3, 3'd1, 3'd1}, {2'd1, 3'd0, 3'd2}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // PLL responder: acknowledge two cycles after a lock request
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (pllLockReq && ackEn && !pllLockAck) begin
        waitCnt++;
        if (waitCnt >= 2) begin
          pllLockAck = 1'b1;
          waitCnt = 0;
        end
      end else begin
        pllLockAck = 1'b0;
      end
    end
  end

  // Regulator responder: one ready pulse every third cycle
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      regReady = regEn && (cnt % 3 == 0);
    end
  end

  // Monitor: voltage at the frequency change, and steps made while halted
  initial begin
    int prevF, prevV;
    @(posedge rstN);
    @(negedge clk);
    prevF = freqCode;
    prevV = voltCode;
    forever begin
      @(negedge clk);
      if (freqCode != prevF) freqChgV = voltCode;
      if (voltCode != prevV && haltExec) haltStepErr++;
      prevF = freqCode;
      prevV = voltCode;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  task automatic pulseIdle(int val);
    @(negedge clk);
    idleValid = 1'b1; idleSample = 8'(val);
    @(negedge clk);
    idleValid = 1'b0; idleSample = '0;
  endtask

  task automatic applyReq(int kind, int arg);
    if (kind == 0) pulseIdle(220);
    else if (kind == 1) begin
      for (int i = 0; i < 3; i++) pulseIdle(10);
    end else begin
      @(negedge clk);
      if (kind == 2) thermTrig = 1'b1;
      else begin swReq = 1'b1; swTarget = IW'(arg); end
      @(negedge clk);
      thermTrig = 1'b0; swReq = 1'b0;
    end
  endtask

  task automatic settle();
    int n = 0;
    repeat (2) @(negedge clk);
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) check("settle timeout", 1, 0);
  endtask

  task automatic checkPoint(string req, int p);
    check({req, " point"}, curPoint, p);
    check({req, " freq"}, freqCode, fOf(p));
    check({req, " volt"}, voltCode, vOf(p));
  endtask

  initial begin
    int prevPt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkPoint("R1", 3);
    check("R1 halt", haltExec, 0);
    check("R1 lockReq", pllLockReq, 0);
    check("R1 busy", busy, 0);

    // Vector walk: R2 R3 R4 R5 R10 and ordering R6 R7
    prevPt = 3;
    for (int i = 0; i < 10; i++) begin
      int kind, arg, expPt;
      kind  = int'(VEC[i][7:6]);
      arg   = int'(VEC[i][5:3]);
      expPt = int'(VEC[i][2:0]);
      freqChgV = -1;
      applyReq(kind, arg);
      settle();
      checkPoint("R2", expPt);
      if (expPt < prevPt) check("R6 volt at relock", freqChgV, vOf(prevPt));
      else if (expPt > prevPt) check("R7 volt at relock", freqChgV, vOf(expPt));
      prevPt = expPt;
    end
    check("R6 no step while halted", haltStepErr, 0);

    // R8: halt held while lock is withheld (point 2 -> 0)
    ackEn = 1'b0;
    applyReq(3, 0);
    repeat (20) @(negedge clk);
    check("R8 halt held", haltExec, 1);
    check("R6 volt held before lock", voltCode, vOf(2));
    check("R6 new freq presented", freqCode, fOf(0));
    ackEn = 1'b1;
    settle();
    checkPoint("R8", 0);

    // R9: no regulator pulses, voltage frozen; frequency still old (R7)
    regEn = 1'b0;
    applyReq(3, 3);
    repeat (20) @(negedge clk);
    check("R9 volt frozen", voltCode, vOf(0));
    check("R7 freq unchanged", freqCode, fOf(0));
    check("R7 no halt during ramp", haltExec, 0);
    regEn = 1'b1;
    settle();
    checkPoint("R9", 3);

    // R4: a busy sample breaks the activity run
    pulseIdle(10); pulseIdle(10); pulseIdle(100); pulseIdle(10); pulseIdle(10);
    settle();
    check("R4 broken run", curPoint, 3);
    pulseIdle(10);
    settle();
    checkPoint("R4", 4);

    // R10: thermal and software in the same cycle, thermal wins
    @(negedge clk);
    thermTrig = 1'b1; swReq = 1'b1; swTarget = 3'd0;
    @(negedge clk);
    thermTrig = 1'b0; swReq = 1'b0;
    settle();
    checkPoint("R10", 3);

    // R11: thermal request during an upward ramp counts from its destination
    applyReq(3, 5);
    repeat (2) @(negedge clk);
    check("R11 running", busy, 1);
    applyReq(2, 0);
    settle();
    checkPoint("R11", 4);

    finishRun();
  end

endmodule